// File: doc/BRIEF.md
# Receive Buffer with HOLD Flow Control

This block is the host-side receive buffer of a serial storage link. The link layer pushes doublewords into it and a DMA-side consumer pops them in arrival order. The buffer holds 128 doublewords. It tracks how many are stored and how much space is left. When the free space falls below a watermark, it raises a HOLD request toward the remote device.

The device does not stop at once. It keeps sending for some cycles before it returns HOLDA, and the buffer has to absorb those words. Bit 2 of an 8-bit configuration input selects the watermark: 32 free doublewords when the bit is 0, or 64 when it is 1. A device that answers HOLD within 20 doublewords fits under either setting. A slower device can send up to 40 doublewords and needs the 64 setting. If a write arrives while the buffer is full, the word is dropped, a sticky overflow flag is set and a one-cycle receive-error pulse tells the link to abort the frame. A skid counter reports how many words came in after HOLD rose and before HOLDA was seen.

Top module: `rx_hold_fifo`

## Requirements
- R1: After reset the buffer is empty: level_o is 0, free_o is 128, rd_valid_o, hold_o, ovf_o and rerr_o are low, and skid_o is 0. The watermark select resets to 0.
- R2: Words leave on rd_data_o in the order they were accepted. rd_valid_o is high whenever level_o is non-zero. A pop happens on a cycle where rd_ready_i and rd_valid_o are both high.
- R3: free_o always equals 128 minus level_o. In a cycle with an accepted write and a pop together, level_o does not change.
- R4: With the latched select at 0, hold_o is high exactly when free_o is below 32.
- R5: With the latched select at 1, hold_o is high exactly when free_o is below 64.
- R6: The select is taken from cfg_i bit 2 only in a cycle with frame_start_i high. A change at any other time has no effect on hold_o until the next frame start.
- R7: With the select at 0, 20 doublewords sent after hold_o rises, while the buffer is not drained, are all stored without overflow.
- R8: A write while level_o is 128 is dropped. The level stays 128 and the stored contents and their order are unchanged.
- R9: ovf_o goes high the cycle after a dropped write. It stays high until a frame_start_i cycle that has no dropped write, and it is low from the cycle after that one.
- R10: rerr_o pulses high for exactly one cycle, in the cycle after a dropped write that occurs while ovf_o is low.
- R11: skid_o counts, with saturation, the cycles that have wr_valid_i high and holda_i low. Counting starts in the first cycle in which hold_o is high, and skid_o is cleared to that cycle's contribution. Counting ends when holda_i is seen or hold_o falls. The value is held until the next rise of HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 8 | Control byte; bit 2 selects the 64-doubleword watermark |
| frame_start_i | input | 1 | Start of frame; latches the select and clears the overflow flag |
| wr_valid_i | input | 1 | Doubleword present from the link layer |
| wr_data_i | input | 32 | Doubleword from the link layer |
| holda_i | input | 1 | HOLD acknowledge from the device |
| rd_ready_i | input | 1 | Consumer takes the head word |
| rd_valid_o | output | 1 | Buffer not empty |
| rd_data_o | output | 32 | Head doubleword |
| level_o | output | 8 | Stored doublewords |
| free_o | output | 8 | Free doublewords |
| hold_o | output | 1 | HOLD request to the device |
| skid_o | output | 8 | Words received after HOLD before HOLDA |
| ovf_o | output | 1 | Sticky overflow flag |
| rerr_o | output | 1 | One-cycle receive-error pulse on overflow |

## Verification
A wrong occupancy count shows up on level_o and free_o one clock after the faulty update. It then shifts the cycle in which hold_o rises or falls, so an off-by-one at either watermark appears within one cycle of reaching it. A damaged pointer or memory word shows up the first time that entry reaches rd_data_o, as a value out of order. A wrong overflow or handshake state shows up on ovf_o, rerr_o or skid_o one cycle after the write that triggers it. The reference model compares every output on every clock, so each of these faults is caught in the cycle it first becomes visible.

// File: rtl/rx_hold_fifo_pkg.sv
package rx_hold_fifo_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_HELD = 2'd2
  } hs_state_e;
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int DW_W  = 32,
  parameter int DEPTH = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [DW_W-1:0]  wdata_i,
  output logic [DW_W-1:0]  rdata_o,
  output logic [CNT_W-1:0] level_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DW_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q, wptr_nx, rptr_nx;
  logic [CNT_W-1:0] cnt_q;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wptr_nx = wptr_q + 1'b1;
      assign rptr_nx = rptr_q + 1'b1;
    end else begin : g_wrap
      assign wptr_nx = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      assign rptr_nx = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_nx;
      if (pop_i)  rptr_q <= rptr_nx;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem[rptr_q];
  assign level_o = cnt_q;
endmodule

// File: rtl/rx_fifo_wm.sv
module rx_fifo_wm #(
  parameter int CNT_W   = 8,
  parameter int CFG_W   = 8,
  parameter int SEL_BIT = 2,
  parameter int WM_LO   = 32,
  parameter int WM_HI   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             frame_start_i,
  input  logic [CNT_W-1:0] free_i,
  output logic             sel_o,
  output logic             hold_o
);
  localparam logic [CNT_W-1:0] LO = CNT_W'(WM_LO);
  localparam logic [CNT_W-1:0] HI = CNT_W'(WM_HI);

  logic sel_q;
  logic unused_cfg;
  assign unused_cfg = ^cfg_i;

  // select is latched only at frame boundaries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            sel_q <= 1'b0;
    else if (frame_start_i) sel_q <= cfg_i[SEL_BIT];
  end

  assign sel_o  = sel_q;
  assign hold_o = free_i < (sel_q ? HI : LO);
endmodule

// File: rtl/rx_fifo_hs.sv
module rx_fifo_hs
  import rx_hold_fifo_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             holda_i,
  input  logic             wr_i,
  output logic [CNT_W-1:0] skid_o
);
  hs_state_e        st_q;
  logic [CNT_W-1:0] skid_q;
  logic             hit;

  assign hit = wr_i && !holda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= HS_IDLE;
      skid_q <= '0;
    end else if (!hold_i) begin
      st_q <= HS_IDLE;
    end else begin
      case (st_q)
        HS_IDLE: begin
          skid_q <= CNT_W'(hit);
          st_q   <= holda_i ? HS_HELD : HS_WAIT;
        end
        HS_WAIT: begin
          if (hit && !(&skid_q)) skid_q <= skid_q + 1'b1;
          if (holda_i) st_q <= HS_HELD;
        end
        default: st_q <= HS_HELD;
      endcase
    end
  end

  assign skid_o = skid_q;
endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo #(
  parameter int DW_W    = 32,
  parameter int DEPTH   = 128,
  parameter int CFG_W   = 8,
  parameter int SEL_BIT = 2,
  parameter int WM_LO   = 32,
  parameter int WM_HI   = 64,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             frame_start_i,
  input  logic             wr_valid_i,
  input  logic [DW_W-1:0]  wr_data_i,
  input  logic             holda_i,
  input  logic             rd_ready_i,
  output logic             rd_valid_o,
  output logic [DW_W-1:0]  rd_data_o,
  output logic [CNT_W-1:0] level_o,
  output logic [CNT_W-1:0] free_o,
  output logic             hold_o,
  output logic [CNT_W-1:0] skid_o,
  output logic             ovf_o,
  output logic             rerr_o
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] level;
  logic full, push, pop, drop, wm_sel;
  logic ovf_q, rerr_q;

  assign full = (level == FULL_C);
  assign push = wr_valid_i && !full;
  assign drop = wr_valid_i && full;
  assign pop  = rd_ready_i && (level != '0);

  rx_fifo_store #(.DW_W(DW_W), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i (push),
    .pop_i  (pop),
    .wdata_i(wr_data_i),
    .rdata_o(rd_data_o),
    .level_o(level)
  );

  assign free_o  = FULL_C - level;
  assign level_o = level;

  rx_fifo_wm #(
    .CNT_W(CNT_W), .CFG_W(CFG_W), .SEL_BIT(SEL_BIT),
    .WM_LO(WM_LO), .WM_HI(WM_HI)
  ) u_wm (
    .clk_i, .rst_ni, .cfg_i, .frame_start_i,
    .free_i(free_o),
    .sel_o (wm_sel),
    .hold_o(hold_o)
  );

  rx_fifo_hs #(.CNT_W(CNT_W)) u_hs (
    .clk_i, .rst_ni,
    .hold_i (hold_o),
    .holda_i(holda_i),
    .wr_i   (wr_valid_i),
    .skid_o (skid_o)
  );

  // drop wins over a same-cycle frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      rerr_q <= 1'b0;
    end else begin
      rerr_q <= drop && !ovf_q;
      if (drop)               ovf_q <= 1'b1;
      else if (frame_start_i) ovf_q <= 1'b0;
    end
  end

  assign ovf_o      = ovf_q;
  assign rerr_o     = rerr_q;
  assign rd_valid_o = (level != '0);
endmodule

// File: rtl/rx_hold_fifo_chk.sv
module rx_hold_fifo_chk #(
  parameter int DEPTH = 128,
  parameter int WM_LO = 32,
  parameter int WM_HI = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_start_i,
  input logic             wr_valid_i,
  input logic             rd_ready_i,
  input logic             rd_valid_o,
  input logic [CNT_W-1:0] level_o,
  input logic [CNT_W-1:0] free_o,
  input logic             hold_o,
  input logic             ovf_o,
  input logic             rerr_o,
  input logic             wm_sel_i
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LO = CNT_W'(WM_LO);
  localparam logic [CNT_W-1:0] HI = CNT_W'(WM_HI);

  a_r3_free_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(free_o) + 32'(level_o)) == DEPTH);

  a_r3_push_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && level_o != FULL_C && rd_ready_i && rd_valid_o) |=> $stable(level_o));

  a_r2_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != '0) |-> rd_valid_o);

  a_r4_hold_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wm_sel_i && free_o < LO) |-> hold_o);

  a_r5_hold_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wm_sel_i && free_o < HI) |-> hold_o);

  a_r4_no_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_o >= HI) |-> !hold_o);

  a_r8_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == FULL_C && wr_valid_i && !rd_ready_i) |=> (level_o == FULL_C));

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !frame_start_i) |=> ovf_o);

  a_r10_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerr_o |=> !rerr_o);

  a_r10_with_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerr_o |-> ovf_o);
endmodule

bind rx_hold_fifo rx_hold_fifo_chk #(
  .DEPTH(DEPTH), .WM_LO(WM_LO), .WM_HI(WM_HI)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .wr_valid_i   (wr_valid_i),
  .rd_ready_i   (rd_ready_i),
  .rd_valid_o   (rd_valid_o),
  .level_o      (level_o),
  .free_o       (free_o),
  .hold_o       (hold_o),
  .ovf_o        (ovf_o),
  .rerr_o       (rerr_o),
  .wm_sel_i     (wm_sel)
);

// File: tb/tb_rx_hold_fifo.sv
module tb_rx_hold_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg = '0;
  logic        fs = 1'b0, wr = 1'b0, ha = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_valid, hold, ovf, rerr;
  logic [31:0] rd_data;
  logic [7:0]  level, free, skid;

  int n_chk = 0, n_fail = 0, rerr_seen = 0;
  logic [31:0] next_data = 32'hA000_0000;
  bit done = 0;

  always #10 clk = ~clk;

  rx_hold_fifo dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .frame_start_i(fs),
    .wr_valid_i(wr), .wr_data_i(wdata), .holda_i(ha), .rd_ready_i(rd),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .level_o(level),
    .free_o(free), .hold_o(hold), .skid_o(skid), .ovf_o(ovf), .rerr_o(rerr)
  );

  // reference model
  logic [31:0] q[$];
  bit ovf_m, rerr_m, sel_m;
  int hs_m, skid_m;

  function automatic bit hold_m();
    return (128 - q.size()) < (sel_m ? 64 : 32);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); ovf_m = 0; rerr_m = 0; sel_m = 0; hs_m = 0; skid_m = 0;
    end else begin
      bit h, full, drop, pop, hit;
      h = hold_m();
      full = (q.size() == 128);
      drop = wr && full;
      pop = rd && (q.size() != 0);
      hit = wr && !ha;
      rerr_m = drop && !ovf_m;
      if (drop) ovf_m = 1; else if (fs) ovf_m = 0;
      if (!h) hs_m = 0;
      else if (hs_m == 0) begin skid_m = hit ? 1 : 0; hs_m = ha ? 2 : 1; end
      else if (hs_m == 1) begin
        if (hit && skid_m < 255) skid_m++;
        if (ha) hs_m = 2;
      end
      if (fs) sel_m = cfg[2];
      if (pop) void'(q.pop_front());
      if (wr && !full) q.push_back(wdata);
    end
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rerr) rerr_seen++;
      check(level == 8'(q.size()), "R3 level", level, q.size());
      check(free == 8'(128 - q.size()), "R3 free", free, 128 - q.size());
      check(rd_valid == (q.size() != 0), "R2 rd_valid", rd_valid, q.size() != 0);
      if (q.size() != 0) check(rd_data == q[0], "R2 order", rd_data, q[0]);
      check(hold == hold_m(), sel_m ? "R5 hold" : "R4 hold", hold, hold_m());
      check(ovf == ovf_m, "R9 ovf", ovf, ovf_m);
      check(rerr == rerr_m, "R10 rerr", rerr, rerr_m);
      check(skid == 8'(skid_m), "R11 skid", skid, skid_m);
    end
  end

  task automatic drive(bit w, bit r, bit f, bit a, logic [7:0] c);
    @(negedge clk);
    wr = w; rd = r; fs = f; ha = a; cfg = c;
    if (w) begin wdata = next_data; next_data++; end
  endtask

  task automatic push_n(int n, logic [7:0] c);
    for (int i = 0; i < n; i++) drive(1, 0, 0, 0, c);
  endtask

  task automatic drain(logic [7:0] c);
    for (int i = 0; i < 130; i++) drive(0, 1, 0, 0, c);
    drive(0, 0, 0, 0, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(level == 0 && free == 128 && !rd_valid && !hold && !ovf && !rerr && skid == 0,
          "R1 reset", {level, free}, {8'd0, 8'd128});
    rst_n = 1'b1;

    // frame, sel=0, push/pop mix
    drive(0, 0, 1, 0, 8'h00);
    push_n(5, 8'h00);
    for (int i = 0; i < 10; i++) drive(1, 1, 0, 0, 8'h00);
    drive(0, 0, 0, 0, 8'h00);
    check(level == 5, "R3 simultaneous push/pop", level, 5);
    drain(8'h00);

    // 20 words after HOLD at low watermark
    push_n(97, 8'h00);
    drive(0, 0, 0, 0, 8'h00);
    check(hold == 1, "R4 hold at free 31", hold, 1);
    push_n(20, 8'h00);
    drive(0, 0, 0, 1, 8'h00);
    drive(0, 0, 0, 0, 8'h00);
    check(ovf == 0 && level == 117, "R7 no loss", level, 117);
    check(skid == 20, "R11 skid count", skid, 20);
    drain(8'h00);

    // select change mid-frame has no effect
    drive(0, 0, 0, 0, 8'h04);
    push_n(65, 8'h04);
    drive(0, 0, 0, 0, 8'h04);
    check(hold == 0, "R6 mid-frame select ignored", hold, 0);
    drain(8'h04);

    // new frame picks up high watermark
    drive(0, 0, 1, 0, 8'h04);
    push_n(65, 8'h00);
    drive(0, 0, 0, 0, 8'h00);
    check(hold == 1, "R5 hold at free 63", hold, 1);
    push_n(40, 8'h00);
    drive(0, 0, 0, 1, 8'h00);
    drive(0, 0, 0, 0, 8'h00);
    check(ovf == 0 && level == 105, "R5 40 words absorbed", level, 105);
    drain(8'h00);

    // low watermark with 40 late words overflows
    drive(0, 0, 1, 0, 8'h00);
    begin
      logic [31:0] first;
      first = next_data;
      rerr_seen = 0;
      push_n(137, 8'h00);
      drive(0, 0, 0, 0, 8'h00);
      check(level == 128, "R8 full level held", level, 128);
      check(rd_data == first, "R8 head intact", rd_data, first);
      check(ovf == 1, "R9 ovf set", ovf, 1);
      drive(1, 0, 0, 0, 8'h00);
      drive(0, 0, 0, 0, 8'h00);
      check(ovf == 1, "R9 ovf sticky", ovf, 1);
      check(rerr_seen == 1, "R10 single pulse", rerr_seen, 1);
    end
    drain(8'h00);
    drive(0, 0, 1, 0, 8'h00);
    drive(0, 0, 0, 0, 8'h00);
    check(ovf == 0, "R9 ovf cleared at frame start", ovf, 0);
    drive(0, 0, 0, 0, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule